// File: doc/BRIEF.md
# Interrupt mask and vector controller

The block collects a vector of level-type interrupt pending lines and gates each with a software-visible enable bit. Among the sources that are both pending and enabled, it picks the one with the lowest index. That winner raises exactly one of three registered request lines toward the processor: normal, critical or system-management. A small routing register chooses which line is used for four designated priority positions. Every other position always uses the normal line.

When the processor acknowledges, the block returns a 7-bit vector code one cycle later. Code n+1 names source n. Code 0 is an error vector. It is returned when an acknowledge finds no enabled pending source, which happens when software disables a source in the same cycle that its request is being taken. No mask bit can suppress the error vector.

The 64 enable bits sit in two 32-bit words. A two-bit select chooses the word for both the write port and the combinational read port. Enable bits keep fixed positions, independent of priority.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset, both enable words and the routing register read 0, all three request outputs are 0 and `vec_valid_o` is 0.
- R2: An enable bit of 1 lets its pending source request, and 0 blocks it. A request output is high if and only if at least one source was pending, enabled and implemented one cycle earlier.
- R3: Bits cleared in parameter `IMPL_MASK` never store a write and always read 0. With the default value, sources 8–11 and 36–39 are unimplemented. Unimplemented sources never request and never win.
- R4: The read port is combinational for select 0 (high word), 1 (low word), 2 (routing register in bits 7:0, upper bits 0) and 3 (always 0). Reading has no side effect on any state or output.
- R5: Select 0 writes sources 63:32 and select 1 writes sources 31:0, with data bit i mapping to source 32·w+i. Select 3 writes are ignored. A write takes effect at the next clock edge.
- R6: Among pending, enabled sources the lowest index wins. An acknowledge returns code index+1.
- R7: Request outputs are registered. They reflect the pending input one clock edge after it changes, and the enable register one edge after it changes.
- R8: `vec_valid_o` is high exactly in the cycle after a cycle with `ack_i` high. `vec_o` is updated at that same edge.
- R9: An acknowledge uses the pending input and the enable bits as they stand after any write in the same cycle. If no source qualifies, code 0 is returned, even when every enable bit is 0.
- R10: Routing field k (register bits 2k+1:2k) steers the default positions 0, 1, 32 and 33 (k = 0..3). Field value 01 selects critical, 10 selects system-management, and 00 or 11 select normal. All other positions use normal.
- R11: At most one request output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 64 | Level pending lines, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 high word, 1 low word, 2 routing, 3 none |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read target, same coding as the write select |
| rd_data_o | output | 32 | Combinational read data |
| ack_i | input | 1 | Vector acknowledge from the processor |
| req_norm_o | output | 1 | Normal interrupt request |
| req_crit_o | output | 1 | Critical interrupt request |
| req_smi_o | output | 1 | System-management interrupt request |
| vec_o | output | 7 | Vector code, 0 = error vector |
| vec_valid_o | output | 1 | Vector code valid |

## Verification
The hardest case to reach from the ports is the withdrawn request: a request is already asserted, and in a single cycle the write that disables its only source and the acknowledge arrive together. Directed steps first establish a single enabled pending source and let its request rise. They then issue the disabling write and the acknowledge in the same cycle, and expect code 0 while the request is still high for that edge. Random cycles that mix sparse pending patterns, writes, reads and acknowledges also produce many same-cycle write/acknowledge overlaps. Each of these is checked against a bench-side model.

// File: rtl/irq_vc_pkg.sv
package irq_vc_pkg;

   localparam logic [1:0] SEL_HI    = 2'd0;
   localparam logic [1:0] SEL_LO    = 2'd1;
   localparam logic [1:0] SEL_ROUTE = 2'd2;
   localparam logic [1:0] SEL_NONE  = 2'd3;

   typedef enum logic [1:0] {
      RT_NORM = 2'b00,
      RT_CRIT = 2'b01,
      RT_SMI  = 2'b10,
      RT_RSVD = 2'b11
   } route_e;

endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
   import irq_vc_pkg::*;
#(
   parameter int unsigned          WORD_W    = 32,
   parameter int unsigned          NUM_SRC   = 64,
   parameter int unsigned          NUM_RT    = 4,
   parameter logic [NUM_SRC-1:0]   IMPL_MASK = '1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [1:0]             wr_sel,
   input  logic [WORD_W-1:0]      wr_data,
   input  logic [1:0]             rd_sel,
   output logic [WORD_W-1:0]      rd_data,
   output logic [NUM_SRC-1:0]     mask_q,
   output logic [NUM_SRC-1:0]     mask_nxt,
   output logic [2*NUM_RT-1:0]    route_q
);

   localparam int unsigned RT_W = 2 * NUM_RT;

   if (NUM_SRC != 2 * WORD_W) begin : g_chk_words
      $error("irq_mask_regs: NUM_SRC must equal two words");
   end
   if (RT_W > WORD_W) begin : g_chk_route
      $error("irq_mask_regs: routing register wider than a word");
   end

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      localparam int unsigned WIDX = b / WORD_W;
      localparam logic [1:0]  WSEL = (WIDX == 1) ? SEL_HI : SEL_LO;
      if (IMPL_MASK[b]) begin : g_impl
         logic bit_q;
         logic bit_d;
         assign bit_d = (wr_en && (wr_sel == WSEL)) ? wr_data[b % WORD_W] : bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
         end
         assign mask_q[b]   = bit_q;
         assign mask_nxt[b] = bit_d;
      end else begin : g_rsvd
         assign mask_q[b]   = 1'b0;
         assign mask_nxt[b] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              route_q <= '0;
      else if (wr_en && (wr_sel == SEL_ROUTE)) route_q <= wr_data[RT_W-1:0];
   end

   always_comb begin
      unique case (rd_sel)
         SEL_HI:    rd_data = mask_q[NUM_SRC-1:WORD_W];
         SEL_LO:    rd_data = mask_q[WORD_W-1:0];
         SEL_ROUTE: rd_data = WORD_W'(route_q);
         default:   rd_data = '0;
      endcase
   end

   // R3: reserved positions never hold a set bit
   a_r3_rsvd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q & ~IMPL_MASK) == '0);

   // R5: a select-3 write leaves every stored bit unchanged
   a_r5_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_NONE) |=> ($stable(mask_q) && $stable(route_q)));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N     = 64,
   parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
)(
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (N < 2) begin : g_chk
      $error("irq_prio_enc: N must be at least 2");
   end

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_route.sv
module irq_route
   import irq_vc_pkg::*;
#(
   parameter int unsigned            NUM_SRC   = 64,
   parameter int unsigned            IDX_W     = 6,
   parameter int unsigned            NUM_RT    = 4,
   parameter logic [NUM_RT*8-1:0]    ROUTE_POS = {8'd33, 8'd32, 8'd1, 8'd0}
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   any,
   input  logic [IDX_W-1:0]       idx,
   input  logic [2*NUM_RT-1:0]    route_q,
   output logic                   req_norm_o,
   output logic                   req_crit_o,
   output logic                   req_smi_o
);

   if (IDX_W > 8) begin : g_chk_idx
      $error("irq_route: index too wide for position table");
   end
   for (genvar k = 0; k < NUM_RT; k++) begin : g_chk_pos
      if (ROUTE_POS[8*k +: 8] >= NUM_SRC) begin : g_bad
         $error("irq_route: routed position outside source range");
      end
   end

   route_e sel;
   logic   spec_hit;

   always_comb begin
      sel      = RT_NORM;
      spec_hit = 1'b0;
      for (int k = 0; k < NUM_RT; k++) begin
         if (any && (8'(idx) == ROUTE_POS[8*k +: 8])) begin
            spec_hit = 1'b1;
            sel      = route_e'(route_q[2*k +: 2]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_norm_o <= 1'b0;
         req_crit_o <= 1'b0;
         req_smi_o  <= 1'b0;
      end else begin
         req_norm_o <= any && (sel == RT_NORM || sel == RT_RSVD);
         req_crit_o <= any && (sel == RT_CRIT);
         req_smi_o  <= any && (sel == RT_SMI);
      end
   end

   // R10: positions outside the routed set only ever use the normal line
   a_r10_plain_normal: assert property (@(posedge clk) disable iff (!rst_n)
      (any && !spec_hit) |=> (req_norm_o && !req_crit_o && !req_smi_o));

   // R11: never more than one request line
   a_r11_one_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_norm_o, req_crit_o, req_smi_o}));

endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
   import irq_vc_pkg::*;
#(
   parameter int unsigned          WORD_W    = 32,
   parameter int unsigned          NUM_SRC   = 2 * WORD_W,
   parameter int unsigned          VEC_W     = 7,
   parameter int unsigned          NUM_RT    = 4,
   parameter logic [NUM_SRC-1:0]   IMPL_MASK = 64'hFFFF_FF0F_FFFF_F0FF,
   parameter logic [NUM_RT*8-1:0]  ROUTE_POS = {8'd33, 8'd32, 8'd1, 8'd0}
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   pend_i,
   input  logic                 wr_en_i,
   input  logic [1:0]           wr_sel_i,
   input  logic [WORD_W-1:0]    wr_data_i,
   input  logic [1:0]           rd_sel_i,
   output logic [WORD_W-1:0]    rd_data_o,
   input  logic                 ack_i,
   output logic                 req_norm_o,
   output logic                 req_crit_o,
   output logic                 req_smi_o,
   output logic [VEC_W-1:0]     vec_o,
   output logic                 vec_valid_o
);

   localparam int unsigned IDX_W = $clog2(NUM_SRC);

   if ((1 << VEC_W) <= NUM_SRC) begin : g_chk_vec
      $error("irq_vector_ctl: VEC_W cannot hold every code plus the error code");
   end

   logic [NUM_SRC-1:0]  mask_q, mask_nxt;
   logic [2*NUM_RT-1:0] route_q;
   logic [NUM_SRC-1:0]  live, eff;
   logic                live_any, eff_any;
   logic [IDX_W-1:0]    live_idx, eff_idx;

   irq_mask_regs #(
      .WORD_W(WORD_W), .NUM_SRC(NUM_SRC), .NUM_RT(NUM_RT), .IMPL_MASK(IMPL_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
      .wr_data(wr_data_i), .rd_sel(rd_sel_i), .rd_data(rd_data_o),
      .mask_q(mask_q), .mask_nxt(mask_nxt), .route_q(route_q)
   );

   // request path uses the stored enables; acknowledge path sees same-cycle writes
   assign live = pend_i & mask_q & IMPL_MASK;
   assign eff  = pend_i & mask_nxt & IMPL_MASK;

   irq_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc_req (
      .req(live), .any(live_any), .idx(live_idx)
   );

   irq_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc_ack (
      .req(eff), .any(eff_any), .idx(eff_idx)
   );

   irq_route #(
      .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .NUM_RT(NUM_RT), .ROUTE_POS(ROUTE_POS)
   ) u_route (
      .clk(clk), .rst_n(rst_n), .any(live_any), .idx(live_idx), .route_q(route_q),
      .req_norm_o(req_norm_o), .req_crit_o(req_crit_o), .req_smi_o(req_smi_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_o       <= '0;
         vec_valid_o <= 1'b0;
      end else begin
         vec_valid_o <= ack_i;
         if (ack_i) vec_o <= eff_any ? (VEC_W'(eff_idx) + VEC_W'(1)) : '0;
      end
   end

   // R2: a request line is high only after a qualifying source was seen
   a_r2_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (req_norm_o || req_crit_o || req_smi_o) |-> $past(live_any));

   // R7: a qualifying source raises a line on the next edge
   a_r7_req_latency: assert property (@(posedge clk) disable iff (!rst_n)
      live_any |=> (req_norm_o || req_crit_o || req_smi_o));

   // R8: valid strobe follows the acknowledge by one edge
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> vec_valid_o);

   // R9: acknowledge with nothing qualifying yields the error code
   a_r9_error_code: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !eff_any) |=> (vec_valid_o && vec_o == '0));

   // R6: acknowledge with a qualifying source never yields the error code
   a_r6_real_code: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && eff_any) |=> (vec_o != '0));

endmodule

// File: tb/irq_vector_ctl_bench.sv
module irq_vector_ctl_bench;

   localparam logic [63:0] IMPL = 64'hFFFF_FF0F_FFFF_F0FF;
   localparam int unsigned POS [4] = '{0, 1, 32, 33};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] pend_i = '0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_sel_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [1:0]  rd_sel_i = '0;
   logic [31:0] rd_data_o;
   logic        ack_i = 1'b0;
   logic        req_norm_o, req_crit_o, req_smi_o;
   logic [6:0]  vec_o;
   logic        vec_valid_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [63:0] m_mask = '0;
   logic [7:0]  m_route = '0;

   always #10 clk = ~clk;

   irq_vector_ctl u_irq_vector_ctl (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .wr_en_i(wr_en_i),
      .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
      .rd_data_o(rd_data_o), .ack_i(ack_i), .req_norm_o(req_norm_o),
      .req_crit_o(req_crit_o), .req_smi_o(req_smi_o), .vec_o(vec_o),
      .vec_valid_o(vec_valid_o)
   );

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] code_of(logic [63:0] q);
      for (int i = 0; i < 64; i++) if (q[i]) return 7'(i + 1);
      return 7'd0;
   endfunction

   // returns {smi, crit, norm}
   function automatic logic [2:0] lines_of(logic [6:0] code);
      logic [1:0] f;
      if (code == 0) return 3'b000;
      f = 2'b00;
      for (int k = 0; k < 4; k++) if (int'(code) - 1 == POS[k]) f = m_route[2*k +: 2];
      if (f == 2'b01) return 3'b010;
      if (f == 2'b10) return 3'b100;
      return 3'b001;
   endfunction

   function automatic logic [31:0] read_of(logic [1:0] s);
      case (s)
         2'd0: return m_mask[63:32];
         2'd1: return m_mask[31:0];
         2'd2: return {24'd0, m_route};
         default: return 32'd0;
      endcase
   endfunction

   task automatic step(logic [63:0] p, logic we, logic [1:0] ws, logic [31:0] wd,
                       logic [1:0] rs, logic ack, string tag);
      logic [63:0] nm;
      logic [2:0]  exp_l;
      logic [6:0]  exp_v;
      pend_i = p; wr_en_i = we; wr_sel_i = ws; wr_data_i = wd; rd_sel_i = rs; ack_i = ack;
      #1;
      check({tag, " R4 read"}, {32'd0, rd_data_o}, {32'd0, read_of(rs)});
      nm = m_mask;
      if (we && ws == 2'd0) nm[63:32] = wd;
      if (we && ws == 2'd1) nm[31:0]  = wd;
      nm = nm & IMPL;
      exp_l = lines_of(code_of(p & m_mask & IMPL));
      exp_v = code_of(p & nm);
      m_mask = nm;
      if (we && ws == 2'd2) m_route = wd[7:0];
      @(posedge clk);
      @(negedge clk);
      check({tag, " R2 R7 lines"}, {61'd0, req_smi_o, req_crit_o, req_norm_o}, {61'd0, exp_l});
      check({tag, " R8 valid"}, {63'd0, vec_valid_o}, {63'd0, ack});
      if (ack) check({tag, exp_v == 0 ? " R9 code" : " R6 code"}, {57'd0, vec_o}, {57'd0, exp_v});
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 lines", {61'd0, req_smi_o, req_crit_o, req_norm_o}, 64'd0);
      check("R1 valid", {63'd0, vec_valid_o}, 64'd0);
      for (int s = 0; s < 3; s++) begin
         rd_sel_i = 2'(s); #1;
         check("R1 read", {32'd0, rd_data_o}, 64'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R9: error code with all enables at zero
      step(64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 1, "R9 all masked");
      // R3 reserved bits stay zero after all-ones writes
      step(0, 1, 2'd0, 32'hFFFF_FFFF, 2'd0, 0, "R3 hi");
      step(0, 1, 2'd1, 32'hFFFF_FFFF, 2'd1, 0, "R3 lo");
      step(0, 0, 0, 0, 2'd1, 0, "R3 lo read");
      check("R3 rsvd lo", {32'd0, rd_data_o & 32'h0000_0F00}, 64'd0);
      rd_sel_i = 2'd0; #1;
      check("R3 rsvd hi", {32'd0, rd_data_o & 32'h0000_00F0}, 64'd0);
      // R6 lowest index wins; R3 unimplemented source ignored
      step(64'h0000_0100_0000_1C00, 0, 0, 0, 0, 1, "R6 R3 prio");
      step(64'h0000_0101_0000_0000, 0, 0, 0, 0, 1, "R5 R6 high word");
      // R5 select 3 write ignored
      step(0, 1, 2'd3, 32'h0, 2'd0, 0, "R5 sel3");
      step(0, 0, 0, 0, 2'd0, 0, "R5 sel3 readback");
      // R10 routing: src0 crit, src1 smi, src32 reserved->normal, src33 crit
      step(0, 1, 2'd2, 32'h0000_0079, 2'd2, 0, "R10 write");
      step(64'h1, 0, 0, 0, 2'd2, 0, "R10 src0");
      step(64'h2, 0, 0, 0, 2'd2, 0, "R10 src1");
      step(64'h0000_0001_0000_0000, 0, 0, 0, 0, 0, "R10 src32");
      step(64'h0000_0002_0000_0000, 0, 0, 0, 0, 0, "R10 src33");
      step(64'h20, 0, 0, 0, 0, 0, "R10 src5");
      check("R10 src5 normal", {61'd0, req_smi_o, req_crit_o, req_norm_o}, 64'd1);
      step(64'h20, 0, 0, 0, 0, 0, "R11 steady");
      // R9 coincident disable and acknowledge
      step(64'h20, 1, 2'd0, 32'h0, 0, 0, "R9 prep hi");
      step(64'h20, 1, 2'd1, 32'h20, 0, 0, "R9 prep lo");
      step(64'h20, 0, 0, 0, 0, 0, "R9 raised");
      check("R9 request up", {63'd0, req_norm_o}, 64'd1);
      step(64'h20, 1, 2'd1, 32'h0, 2'd1, 1, "R9 coincide");
      check("R9 coincide code", {57'd0, vec_o}, 64'd0);
      step(64'h20, 0, 0, 0, 0, 0, "R7 drop");
      // R7 latency from the pending input
      step(0, 1, 2'd1, 32'hFFFF_FFFF, 0, 0, "R7 enable");
      step(64'h4, 0, 0, 0, 0, 0, "R7 rise");
      step(64'h0, 0, 0, 0, 0, 0, "R7 fall");

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [63:0] p;
         logic        we, ak;
         p  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         if (($urandom % 4) == 0) p = p & {$urandom, $urandom} & {$urandom, $urandom};
         we = (($urandom % 4) == 0);
         ak = (($urandom % 3) == 0);
         step(p, we, 2'($urandom), $urandom, 2'($urandom), ak, "RND");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule